// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block sits between a processor core and its memory regions and decides how many bus-clock periods each access takes. Every accepted request is sorted by address into one of three region classes: the special-function register window, internal RAM or ROM, or one of four external chip-select windows. The cycle length is then set by a fixed priority.

The priority works as follows:
- The register window always takes 2 clocks.
- A multiplexed external access always takes 3 clocks.
- A global wait bit forces every other access to 2 clocks.
- When the global bit is clear, internal memory runs in 1 clock and each external window runs in 1 or 2 clocks according to its own fast bit.

Requests arrive on a valid/ready interface. The requester raises `req_valid` with address, direction, write data and the multiplex flag, and holds all of them stable until `req_ready` is high at a rising edge. The block raises `req_ready` when it is idle or in the final clock of the current access, so equal-length accesses can run back to back with no gap. `done` is high for exactly the final clock of each access. For a read of a control register, the value is presented on `rd_data` during that clock.

The block holds three control registers inside the register window:
- a control register carrying the global wait bit,
- a chip-select wait register carrying one fast bit per window,
- a protect register whose enable bit must be set before the global wait bit can change.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, the global wait bit, all chip-select fast bits and the protect bit are 0, each of the three control registers reads as 0, `req_ready` is 1 and `done` is 0.
- R2: An access to addresses 0x0000-0x03FF (register window) always lasts 2 clocks, whatever the wait bits and `req_mux` are.
- R3: An access to internal RAM (0x0400-0x3FFF) or internal ROM (0xE000-0xFFFF) lasts 1 clock when the global wait bit is 0, and `req_mux` has no effect on it.
- R4: External windows CS0..CS3 are 0x4000-0x5FFF, 0x6000-0x7FFF, 0x8000-0x9FFF and 0xA000-0xBFFF. The fast bit for CSn is bit 4+n of the chip-select wait register at 0x011. With `req_mux`=0 and the global bit 0, an access lasts 1 clock if that bit is 1 and 2 clocks if it is 0.
- R5: The global wait bit is bit 7 of the control register at 0x010. When it is 1, every internal or non-multiplexed external access lasts 2 clocks, whatever the fast bits are.
- R6: An external access with `req_mux`=1 always lasts 3 clocks.
- R7: An address in 0xC000-0xDFFF, which hits no region, is handled as CS0.
- R8: A write to the control register changes the global wait bit only while bit 1 of the protect register at 0x012 is 1. Otherwise the register keeps its value.
- R9: `req_ready` is 1 when the block is idle or in the final clock of an access, and 0 otherwise. `done` is 1 only in the final clock. A request held valid through the final clock is accepted at that edge with no idle gap.
- R10: A read of a control register returns its value on `rd_data` in the clock where `done` is 1. Bits with no function read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data for control registers |
| req_mux | input | 1 | Target external window uses the multiplexed bus |
| done | output | 1 | Final clock of the current access |
| rd_data | output | 8 | Control register read value, valid while done is 1 |

## Verification
An access accepted at a rising edge raises `done` after exactly its length in clocks: one edge for a fast access, two for a waited or register access, three for a multiplexed one. `req_ready` falls in the clocks between acceptance and `done`. The bench drives inputs on falling edges and counts falling edges after the accepting edge until it sees `done`, so the count equals the cycle length. It samples `rd_data`, `done` and `req_ready` at that same falling edge. Register writes take effect at the accepting edge, so every read or timed access that follows already sees the new setting.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    RGN_REG = 2'd0,
    RGN_INT = 2'd1,
    RGN_EXT = 2'd2
  } region_e;
endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
  import bwc_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          NUM_CS  = 4,
  parameter int unsigned REG_HI  = 'h03FF,
  parameter int unsigned RAM_LO  = 'h0400,
  parameter int unsigned RAM_HI  = 'h3FFF,
  parameter int unsigned ROM_LO  = 'hE000,
  parameter int unsigned ROM_HI  = 'hFFFF,
  parameter int unsigned CS_BASE = 'h4000,
  parameter int unsigned CS_SPAN = 'h2000,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [AW-1:0]   addr,
  output region_e         rgn,
  output logic [CS_W-1:0] cs_idx
);
  logic [31:0]       a32;
  logic [NUM_CS-1:0] hit;

  assign a32 = 32'(addr);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign hit[g] = (a32 >= CS_BASE + g * CS_SPAN) &&
                    (a32 <  CS_BASE + (g + 1) * CS_SPAN);
  end

  always_comb begin
    if (a32 <= REG_HI)
      rgn = RGN_REG;
    else if ((a32 >= RAM_LO && a32 <= RAM_HI) || (a32 >= ROM_LO && a32 <= ROM_HI))
      rgn = RGN_INT;
    else
      rgn = RGN_EXT;
  end

  // lowest matching window wins; no hit falls back to window 0
  always_comb begin
    cs_idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (hit[i]) cs_idx = CS_W'(i);
  end
endmodule

// File: rtl/bwc_regs.sv
module bwc_regs #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          NUM_CS    = 4,
  parameter int unsigned CTRL_ADDR = 'h010,
  parameter int unsigned CSW_ADDR  = 'h011,
  parameter int unsigned PROT_ADDR = 'h012,
  parameter int          GLOB_BIT  = 7,
  parameter int          CSW_LSB   = 4,
  parameter int          PROT_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic              glob_wait,
  output logic [NUM_CS-1:0] cs_fast,
  output logic              prot_on,
  output logic [DW-1:0]     rd_val
);
  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_wait <= 1'b0;
      cs_fast   <= '0;
      prot_on   <= 1'b0;
    end else if (wr_en) begin
      if (a32 == PROT_ADDR) prot_on <= wdata[PROT_BIT];
      if (a32 == CTRL_ADDR && prot_on) glob_wait <= wdata[GLOB_BIT];
      if (a32 == CSW_ADDR) cs_fast <= wdata[CSW_LSB +: NUM_CS];
    end
  end

  always_comb begin
    rd_val = '0;
    if (a32 == CTRL_ADDR) rd_val[GLOB_BIT] = glob_wait;
    if (a32 == CSW_ADDR)  rd_val[CSW_LSB +: NUM_CS] = cs_fast;
    if (a32 == PROT_ADDR) rd_val[PROT_BIT] = prot_on;
  end
endmodule

// File: rtl/bwc_len.sv
module bwc_len
  import bwc_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int LEN_FAST = 1,
  parameter int LEN_WAIT = 2,
  parameter int LEN_REG  = 2,
  parameter int LEN_MUX  = 3,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W = $clog2(LEN_MUX + 1)
) (
  input  region_e           rgn,
  input  logic [CS_W-1:0]   cs_idx,
  input  logic              mux,
  input  logic              glob_wait,
  input  logic [NUM_CS-1:0] cs_fast,
  output logic [LEN_W-1:0]  len
);
  always_comb begin
    unique case (rgn)
      RGN_REG: len = LEN_W'(LEN_REG);
      RGN_INT: len = glob_wait ? LEN_W'(LEN_WAIT) : LEN_W'(LEN_FAST);
      default: begin
        if (mux)
          len = LEN_W'(LEN_MUX);
        else if (glob_wait || !cs_fast[cs_idx])
          len = LEN_W'(LEN_WAIT);
        else
          len = LEN_W'(LEN_FAST);
      end
    endcase
  end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          NUM_CS    = 4,
  parameter int unsigned CTRL_ADDR = 'h010,
  parameter int unsigned CSW_ADDR  = 'h011,
  parameter int unsigned PROT_ADDR = 'h012,
  parameter int          LEN_MUX   = 3,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W = $clog2(LEN_MUX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_mux,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  region_e           rgn;
  logic [CS_W-1:0]   cs_idx;
  logic              glob_wait;
  logic [NUM_CS-1:0] cs_fast;
  logic              prot_on;
  logic [DW-1:0]     rd_val;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  cnt;
  logic [DW-1:0]     rd_q;
  logic              accept;
  logic              reg_wr;

  bwc_decode #(.AW(AW), .NUM_CS(NUM_CS)) u_decode (
    .addr(req_addr), .rgn(rgn), .cs_idx(cs_idx)
  );

  bwc_regs #(
    .AW(AW), .DW(DW), .NUM_CS(NUM_CS),
    .CTRL_ADDR(CTRL_ADDR), .CSW_ADDR(CSW_ADDR), .PROT_ADDR(PROT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(req_addr),
    .wdata(req_wdata), .glob_wait(glob_wait), .cs_fast(cs_fast),
    .prot_on(prot_on), .rd_val(rd_val)
  );

  bwc_len #(.NUM_CS(NUM_CS), .LEN_MUX(LEN_MUX)) u_len (
    .rgn(rgn), .cs_idx(cs_idx), .mux(req_mux), .glob_wait(glob_wait),
    .cs_fast(cs_fast), .len(len)
  );

  assign done      = (cnt == LEN_W'(1));
  assign req_ready = (cnt == '0) || done;
  assign accept    = req_valid && req_ready;
  assign reg_wr    = accept && req_write && (rgn == RGN_REG);
  assign rd_data   = done ? rd_q : '0;

  // length is taken from settings before this access's own write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rd_q <= '0;
    end else if (accept) begin
      cnt  <= len;
      rd_q <= (!req_write && rgn == RGN_REG) ? rd_val : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - LEN_W'(1);
    end
  end
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk #(
  parameter int          AW        = 16,
  parameter int unsigned CTRL_ADDR = 'h010,
  parameter int unsigned REG_HI    = 'h03FF,
  parameter int unsigned RAM_LO    = 'h0400,
  parameter int unsigned RAM_HI    = 'h3FFF,
  parameter int unsigned ROM_LO    = 'hE000,
  parameter int unsigned ROM_HI    = 'hFFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic          req_mux,
  input logic          done,
  input logic          glob_q,
  input logic          prot_q
);
  logic [31:0] a32;
  logic acc, in_reg, in_int, in_ext;
  assign a32    = 32'(req_addr);
  assign acc    = req_valid && req_ready;
  assign in_reg = (a32 <= REG_HI);
  assign in_int = (a32 >= RAM_LO && a32 <= RAM_HI) || (a32 >= ROM_LO && a32 <= ROM_HI);
  assign in_ext = !in_reg && !in_int;

  assert_reg_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_reg |=> !done ##1 done);

  assert_int_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_int && !glob_q |=> done);

  assert_mux_three_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_ext && req_mux |=> !done ##1 !done ##1 done);

  assert_protect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && a32 == CTRL_ADDR && !prot_q |=> $stable(glob_q));

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> !done && req_ready);
endmodule

bind bus_wait_ctrl bwc_chk #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_mux(req_mux),
  .done(done), .glob_q(glob_wait), .prot_q(prot_on)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        req_write;
  logic [7:0]  req_wdata;
  logic        req_mux;
  logic        done;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;

  localparam logic [15:0] A_CTRL = 16'h0010;
  localparam logic [15:0] A_CSW  = 16'h0011;
  localparam logic [15:0] A_PROT = 16'h0012;

  always #2 clk = ~clk;

  bus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_mux(req_mux), .done(done), .rd_data(rd_data)
  );

  // {glob, csw nibble, addr, mux, expected length, tag index}
  localparam int NV = 17;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 4'b0000, 16'h0100, 1'b0, 2'd2, 4'd2},  // R2
    {1'b1, 4'b1111, 16'h0200, 1'b1, 2'd2, 4'd2},  // R2
    {1'b0, 4'b0000, 16'h1000, 1'b0, 2'd1, 4'd3},  // R3
    {1'b0, 4'b0000, 16'hE000, 1'b1, 2'd1, 4'd3},  // R3
    {1'b1, 4'b0000, 16'h1000, 1'b0, 2'd2, 4'd5},  // R5
    {1'b1, 4'b1111, 16'hF000, 1'b0, 2'd2, 4'd5},  // R5
    {1'b0, 4'b0001, 16'h4000, 1'b0, 2'd1, 4'd4},  // R4
    {1'b0, 4'b1110, 16'h5FFF, 1'b0, 2'd2, 4'd4},  // R4
    {1'b0, 4'b0010, 16'h6000, 1'b0, 2'd1, 4'd4},  // R4
    {1'b0, 4'b1101, 16'h7000, 1'b0, 2'd2, 4'd4},  // R4
    {1'b0, 4'b0100, 16'h8000, 1'b0, 2'd1, 4'd4},  // R4
    {1'b0, 4'b1000, 16'hBFFF, 1'b0, 2'd1, 4'd4},  // R4
    {1'b1, 4'b1111, 16'hA000, 1'b0, 2'd2, 4'd5},  // R5
    {1'b0, 4'b1111, 16'h8000, 1'b1, 2'd3, 4'd6},  // R6
    {1'b1, 4'b0000, 16'h4000, 1'b1, 2'd3, 4'd6},  // R6
    {1'b0, 4'b0001, 16'hC000, 1'b0, 2'd1, 4'd7},  // R7
    {1'b0, 4'b1110, 16'hD000, 1'b0, 2'd2, 4'd7}   // R7
  };

  function automatic string tag(input int k);
    case (k)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic m, output int len, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_mux = m;
    while (!req_ready) @(negedge clk);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!done && len < 10);
    rd = rd_data;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    int l; logic [7:0] r;
    access(a, 1'b1, d, 1'b0, l, r);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int l; logic [7:0] r;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_wdata = '0; req_mux = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 done", int'(done), 0);
    access(A_CTRL, 1'b0, 8'h00, 1'b0, l, r); chk("R1 ctrl", int'(r), 0);
    chk("R2 reg read length", l, 2);
    access(A_CSW, 1'b0, 8'h00, 1'b0, l, r);  chk("R1 csw", int'(r), 0);
    access(A_PROT, 1'b0, 8'h00, 1'b0, l, r); chk("R1 prot", int'(r), 0);

    for (int i = 0; i < NV; i++) begin
      wr(A_PROT, 8'h02);
      wr(A_CTRL, {VEC[i][27], 7'b0});
      wr(A_CSW, {VEC[i][26:23], 4'b0});
      access(VEC[i][22:7], 1'b0, 8'h00, VEC[i][6], l, r);
      chk(tag(int'(VEC[i][3:0])), l, int'(VEC[i][5:4]));
    end

    // R8: protect off blocks the global bit
    wr(A_CTRL, 8'h00);
    wr(A_PROT, 8'h00);
    wr(A_CTRL, 8'h80);
    access(A_CTRL, 1'b0, 8'h00, 1'b0, l, r); chk("R8 ctrl unchanged", int'(r), 0);
    access(16'h2000, 1'b0, 8'h00, 1'b0, l, r); chk("R8 ram still fast", l, 1);
    wr(A_PROT, 8'h02);
    access(A_PROT, 1'b0, 8'h00, 1'b0, l, r); chk("R10 prot readback", int'(r), 8'h02);
    wr(A_CTRL, 8'hFF);
    access(A_CTRL, 1'b0, 8'h00, 1'b0, l, r); chk("R10 ctrl readback", int'(r), 8'h80);
    access(16'h2000, 1'b0, 8'h00, 1'b0, l, r); chk("R8 ram waited", l, 2);
    wr(A_CSW, 8'hA5);
    access(A_CSW, 1'b0, 8'h00, 1'b0, l, r); chk("R10 csw readback", int'(r), 8'hA0);

    // R9: back-to-back fast accesses with valid held high
    wr(A_CTRL, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0800; req_write = 1'b0; req_mux = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 back-to-back done", int'(done), 1);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle done", int'(done), 0);
    chk("R9 idle ready", int'(req_ready), 1);

    // R9: ready low inside a multiplexed access
    req_valid = 1'b1; req_addr = 16'h4000; req_mux = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy ready", int'(req_ready), 0);
    @(negedge clk);
    chk("R9 busy done", int'(done), 0);
    @(negedge clk);
    chk("R9 final done", int'(done), 1);
    chk("R9 final ready", int'(req_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule